// File: doc/BRIEF.md
# Serial Transmit Path with Selectable Buffering and Oversampling

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each host write either enters a 32-entry first-in first-out store or, when buffering is switched off, lands in a one-byte holding slot. A shifter takes the oldest waiting byte and sends it as a frame with these parts:

- a low start bit;
- five to eight data bits, least significant first;
- an optional odd or even parity bit;
- one or two high stop bits.

Bit timing comes from a single-cycle tick enable that the block receives at the oversampling rate. Every bit on the line lasts 16, 8 or 4 ticks. The ratio can be changed while the block runs. Two flags report status: one shows that no byte is waiting, and one shows that the whole transmitter has gone quiet. The host uses these flags to pace its writes.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. `hold_empty` and `tx_idle` are 1 after reset.
- R2: A frame begins with one start bit at 0. The data bits follow, bit 0 of the written byte first. The count of data bits is 5 + `word_len`, so codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits.
- R3: When `par_en` is 1, one parity bit follows the data bits. With `par_odd` = 1 the data bits and the parity bit together hold an odd number of ones. With `par_odd` = 0 they hold an even number.
- R4: After the data bits, or after the parity bit when there is one, the line is 1 for one stop bit, or for two stop bits when `two_stop` is 1.
- R5: Every bit lasts exactly 16 ticks when `os_mode` is 0 or 3, 8 ticks when it is 1, and 4 ticks when it is 2. The tick on which a frame is loaded counts as the first tick of its start bit.
- R6: With `fifo_on` = 1, up to 32 written bytes are held. They are sent in the order they were written.
- R7: With `fifo_on` = 0, only one byte is held. A write while that byte still waits is dropped.
- R8: A write while 32 bytes are held is dropped, and no frame is ever sent for it.
- R9: `hold_empty` is 1 exactly when no byte is waiting. `tx_idle` is 1 exactly when no byte is waiting and no frame is in progress.
- R10: `txd` changes only in the cycle after a tick. If a byte is waiting when a frame's last stop bit ends, the next frame loads on the very next tick.
- R11: The word length, parity and stop settings are captured when a frame loads. Changing them during that frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable at the oversampling rate |
| fifo_on | input | 1 | 1 selects the 32-entry store, 0 the single holding slot |
| os_mode | input | 2 | Ticks per bit: 0 or 3 gives 16, 1 gives 8, 2 gives 4 |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | No byte waiting |
| tx_idle | output | 1 | No byte waiting and the shifter is quiet |

## Verification
The embedded properties assume three things about the inputs:

- `tick` is a clean one-cycle pulse.
- The framing controls are only meaningful at frame load.
- `fifo_on` is held steady while bytes are waiting.

The stimulus respects all three. It raises ticks every other cycle from a dedicated generator, and it changes `fifo_on` and `os_mode` only while the transmitter is quiet. It changes the framing settings during a frame only in the capture test. There, the bench records the settings that were in force at the write, so the expected frame is built from those.

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fifo_on,
  input  logic [1:0] os_mode,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_idle
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  st_t         st;
  logic [3:0]  sub, lm1;
  logic [7:0]  sr;
  logic [2:0]  bitn;
  logic [1:0]  f_len;
  logic        f_pe, f_two, stop2, pbit;

  wire [AW:0] cap  = fifo_on ? (AW+1)'(DEPTH) : (AW+1)'(1);
  wire        push = wr_en && (cnt < cap);
  wire        pop  = tick && (st == S_IDLE) && (cnt != 0);
  wire [7:0]  head = mem[rp];
  wire [7:0]  mask = 8'hFF >> (2'd3 - word_len);

  assign hold_empty = (cnt == 0);
  assign tx_idle    = hold_empty && (st == S_IDLE);

  always_comb
    case (os_mode)
      2'd1:    lm1 = 4'd7;
      2'd2:    lm1 = 4'd3;
      default: lm1 = 4'd15;
    endcase

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      txd   <= 1'b1;
      sub   <= '0;
      sr    <= '0;
      bitn  <= '0;
      pbit  <= 1'b0;
      stop2 <= 1'b0;
      f_len <= '0;
      f_pe  <= 1'b0;
      f_two <= 1'b0;
    end else if (tick) begin
      if (st == S_IDLE) begin
        if (cnt != 0) begin
          st    <= S_START;
          txd   <= 1'b0;
          sub   <= 4'd1;
          sr    <= head;
          bitn  <= '0;
          pbit  <= (^(head & mask)) ^ par_odd;
          stop2 <= 1'b0;
          f_len <= word_len;
          f_pe  <= par_en;
          f_two <= two_stop;
        end
      end else if (sub < lm1) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          S_START: begin
            st  <= S_DATA;
            txd <= sr[0];
          end
          S_DATA:
            if (bitn == {1'b1, f_len}) begin
              if (f_pe) begin
                st  <= S_PAR;
                txd <= pbit;
              end else begin
                st  <= S_STOP;
                txd <= 1'b1;
              end
            end else begin
              sr   <= {1'b0, sr[7:1]};
              txd  <= sr[1];
              bitn <= bitn + 1'b1;
            end
          S_PAR: begin
            st  <= S_STOP;
            txd <= 1'b1;
          end
          S_STOP:
            if (f_two && !stop2) stop2 <= 1'b1;
            else                 st    <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  // R7
  hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fifo_on && cnt != 0 && !pop) |=> (cnt == $past(cnt)));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> txd);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) |-> !txd);

  // R10
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  // R9
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> hold_empty);
endmodule

// File: tb/uart_tx_path_test.sv
`timescale 1ns/1ps
module uart_tx_path_test;
  logic clk = 0, rst_n = 0, tick = 0, tick_on = 0;
  logic fifo_on = 0, par_en = 0, par_odd = 0, two_stop = 0, wr_en = 0;
  logic [1:0] os_mode = 0, word_len = 3;
  logic [7:0] wr_data = 0;
  wire txd, hold_empty, tx_idle;

  uart_tx_path uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_on(fifo_on), .os_mode(os_mode),
    .word_len(word_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle));

  always #2.5 clk = ~clk;

  int tickn = 0;
  always @(negedge clk) tick <= tick_on && !tick;
  always @(posedge clk) if (tick) tickn <= tickn + 1;

  typedef struct {
    logic [7:0] d;
    int nb;
    bit pe, po, ts;
    int len;
    bit gap;
    string tag;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0, frames = 0;
  bit mon_busy = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int blen(logic [1:0] m);
    case (m)
      2'd1:    return 8;
      2'd2:    return 4;
      default: return 16;
    endcase
  endfunction

  task automatic put(logic [7:0] b);
    @(negedge clk);
    wr_en = 1;
    wr_data = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(logic [7:0] b, bit gap, string tag);
    item_t it;
    it.d = b; it.nb = 5 + int'(word_len); it.pe = par_en; it.po = par_odd;
    it.ts = two_stop; it.len = blen(os_mode); it.gap = gap; it.tag = tag;
    q.push_back(it);
    put(b);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (q.size() != 0 || mon_busy || !tx_idle);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes frames, compares against the queue
  initial begin
    item_t it;
    int t0, n, len, k, exp_next;
    bit bits [12];
    string r;
    exp_next = -1;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        mon_busy = 1;
        t0 = tickn;
        if (q.size() == 0) begin
          chk(0, "R7/R8", "frame with no pending write", 1, 0);
          do @(negedge clk); while (tx_idle !== 1'b1);
        end else begin
          it = q.pop_front();
          frames++;
          if (it.gap) chk(t0 == exp_next, "R10", "load tick of next frame", t0, exp_next);
          len = it.len;
          n = 0;
          bits[n++] = 0;
          for (int i = 0; i < it.nb; i++) bits[n++] = it.d[i];
          if (it.pe) bits[n++] = (^(it.d & (8'hFF >> (8 - it.nb)))) ^ it.po;
          bits[n++] = 1;
          if (it.ts) bits[n++] = 1;
          for (int i = 0; i < n; i++) begin
            if (i == 0) r = "R2 start";
            else if (i <= it.nb) r = {"R2 data ", it.tag};
            else if (it.pe && i == it.nb + 1) r = "R3 parity";
            else r = "R4 stop";
            for (int s = 0; s < 2; s++) begin
              k = (s == 1) ? i * len + len - 1 : ((i == 0) ? 1 : i * len);
              while (tickn < t0 + k - 1) @(negedge clk);
              chk(txd == bits[i], {r, "/R5"}, $sformatf("bit %0d tick %0d", i, k),
                  int'(txd), int'(bits[i]));
            end
          end
          k = n * len;
          while (tickn < t0 + k - 1) @(negedge clk);
          chk(txd == 1'b1, "R10", "line after last stop", int'(txd), 1);
          exp_next = t0 + n * len;
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1", "txd after reset", int'(txd), 1);
    chk(hold_empty == 1, "R1", "hold_empty after reset", int'(hold_empty), 1);
    chk(tx_idle == 1, "R1", "tx_idle after reset", int'(tx_idle), 1);

    // single holding slot, 8N1, 16 ticks per bit
    fifo_on = 0; os_mode = 0; word_len = 3;
    send(8'hA5, 0, "R7");
    @(negedge clk);
    chk(hold_empty == 0, "R9", "hold_empty with byte waiting", int'(hold_empty), 0);
    chk(tx_idle == 0, "R9", "tx_idle with byte waiting", int'(tx_idle), 0);
    put(8'h3C);
    tick_on = 1;
    do @(negedge clk); while (!hold_empty);
    chk(tx_idle == 0, "R9", "tx_idle while shifting", int'(tx_idle), 0);
    chk(txd == 0, "R2", "start bit after load", int'(txd), 0);
    send(8'h5A, 1, "R10");
    wait_done();

    // five bits, odd parity, two stops, 8 ticks per bit
    os_mode = 1; word_len = 0; par_en = 1; par_odd = 1; two_stop = 1;
    send(8'h13, 0, "R3");
    wait_done();
    // six bits, even parity, one stop, 4 ticks per bit
    os_mode = 2; word_len = 1; par_odd = 0; two_stop = 0;
    send(8'h2E, 0, "R3");
    wait_done();
    // seven bits, odd parity, two stops, mode code 3
    os_mode = 3; word_len = 2; par_odd = 1; two_stop = 1;
    send(8'h7F, 0, "R4");
    wait_done();

    // 32-entry store filled while ticks are held off, then two extra writes
    fifo_on = 1; os_mode = 2; word_len = 3; par_en = 0; two_stop = 0;
    tick_on = 0;
    repeat (4) @(negedge clk);
    f0 = frames;
    for (int i = 0; i < 32; i++) send(8'(i * 37 + 11), i != 0, "R6");
    put(8'hEE);
    put(8'hDD);
    @(negedge clk);
    chk(hold_empty == 0, "R6", "hold_empty with full store", int'(hold_empty), 0);
    tick_on = 1;
    wait_done();
    chk(frames - f0 == 32, "R8", "frames sent from full store", frames - f0, 32);

    // settings change after load does not alter the frame in flight
    send(8'hC3, 0, "R11");
    do @(negedge clk); while (!hold_empty);
    word_len = 0; par_en = 1; two_stop = 1;
    wait_done();
    word_len = 3; par_en = 0; two_stop = 0;

    chk(hold_empty == 1, "R9", "hold_empty at end", int'(hold_empty), 1);
    chk(tx_idle == 1, "R9", "tx_idle at end", int'(tx_idle), 1);
    chk(txd == 1, "R1", "idle line at end", int'(txd), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule